// File: doc/BRIEF.md
# One-Time-Programmable Protection Register Programmer

This block holds a one-time-programmable protection area of 2112 data bits and the word-wide command sequence that writes it. The area is one 64-bit segment and sixteen 128-bit segments. It is addressed in 16-bit words on a small word-address bus. Two lock bits sit in their own word. Once a lock bit is programmed, it guards a group of segments against any further write.

Writing takes two bus writes. The first write arms the sequence. The second write supplies the target address and the data and starts a program operation of fixed length. While that operation runs, reads return a status word. Programming ANDs the supplied data into the stored word, so bits can only go from 1 to 0. A write to a locked segment, or to an address outside the area, changes nothing and raises a sticky error flag in the status word. A program operation cannot be suspended, and every bus write made while it runs is ignored.

Word map:
- Address 0 is the lock word.
- Addresses 1 to 4 are the 64-bit segment.
- Addresses 5 to 132 are the sixteen 128-bit segments, eight words each.

Top module: `otp_prog_reg`

## Requirements
- R1: After reset every data word and the lock word read 0xFFFF. Reads start in array mode, and the status word shows ready with no error.
- R2: A program operation stores the AND of the old word and the supplied data. Bits already at 0 stay 0.
- R3: A bus write with low byte 0xC0 arms the sequence. The next bus write latches its address and data and starts the operation.
- R4: While an operation runs, `rd_data` returns the status word with the ready bit (bit 7) at 0. After an operation starts, reads stay in status mode until a write with low byte 0xFF selects array mode. Low byte 0x70 also selects status mode.
- R5: The ready bit returns to 1 exactly PROG_LAT cycles after the clock edge that accepted the second write. An idle, error-free status word reads 0x0080.
- R6: Programming an address above 132 writes nothing and sets the error bit (bit 4), so status reads 0x0090. An array read of such an address returns 0xFFFF.
- R7: In the lock word (address 0), bit 0 is lock A and bit 1 is lock B. Both are active low and are programmed by AND, so a set lock can never be cleared.
- R8: Lock A guards addresses 1 to 12 and lock B guards addresses 13 to 132. Programming a guarded word leaves it unchanged and sets the error bit.
- R9: Bus writes made while an operation runs are ignored, including 0xC0, 0xFF and any suspend attempt.
- R10: In idle, a write with low byte 0x50 clears the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Bus write strobe, one write per cycle |
| bus_addr | input | 8 | Word address of the bus write |
| bus_wdata | input | 16 | Bus write data; low byte carries the command code |
| rd_addr | input | 8 | Word address for array reads |
| rd_data | output | 16 | Array word or status word, depending on read mode |

## Verification
The arming write takes effect at its own clock edge. The launching write makes the status read busy right after its edge. Ready returns at the PROG_LAT-th edge after that. The stored word and the error bit change at that same edge, and read-mode commands act at the edge that accepts them. The bench drives each write on a falling edge and samples `rd_data` on the falling edge after the edge where the result is due. In the latency scenario it samples at every falling edge in between, so a result that arrives one cycle early or late shows up as a mismatch.

// File: rtl/otpr_pkg.sv
package otpr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_BUSY  = 2'd2
  } otpr_state_e;

  localparam logic [7:0] CMD_ARM       = 8'hC0;
  localparam logic [7:0] CMD_CLR_ERR   = 8'h50;
  localparam logic [7:0] CMD_SHOW_ARR  = 8'hFF;
  localparam logic [7:0] CMD_SHOW_STAT = 8'h70;

  localparam int STAT_READY_BIT = 7;
  localparam int STAT_ERR_BIT   = 4;
endpackage

// File: rtl/otpr_seq.sv
module otpr_seq
  import otpr_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int PROG_LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          fault,
  output logic          armed,
  output logic          busy,
  output logic          commit,
  output logic          show_status,
  output logic [AW-1:0] lat_addr,
  output logic [DW-1:0] lat_data,
  output logic [DW-1:0] stat_word
);
  localparam int CW = (PROG_LAT < 2) ? 1 : $clog2(PROG_LAT);
  localparam logic [CW-1:0] CNT_LOAD = CW'(PROG_LAT - 1);

  otpr_state_e   st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          mode_q, mode_d;
  logic          err_q, err_d;
  logic          lat_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    err_d  = err_q;
    lat_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (bus_we) begin
          unique case (bus_wdata[7:0])
            CMD_ARM:       st_d   = ST_ARMED;
            CMD_CLR_ERR:   err_d  = 1'b0;
            CMD_SHOW_ARR:  mode_d = 1'b0;
            CMD_SHOW_STAT: mode_d = 1'b1;
            default:       st_d   = ST_IDLE;
          endcase
        end
      end
      ST_ARMED: begin
        if (bus_we) begin
          lat_en = 1'b1;
          st_d   = ST_BUSY;
          cnt_d  = CNT_LOAD;
          mode_d = 1'b1;
        end
      end
      ST_BUSY: begin
        if (cnt_q == '0) begin
          st_d  = ST_IDLE;
          err_d = err_q | fault;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      mode_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr <= '0;
      lat_data <= '1;
    end else if (lat_en) begin
      lat_addr <= bus_addr;
      lat_data <= bus_wdata;
    end
  end

  assign armed       = (st_q == ST_ARMED);
  assign busy        = (st_q == ST_BUSY);
  assign commit      = busy && (cnt_q == '0);
  assign show_status = mode_q;

  always_comb begin
    stat_word                 = '0;
    stat_word[STAT_READY_BIT] = ~busy;
    stat_word[STAT_ERR_BIT]   = err_q;
  end
endmodule

// File: rtl/otpr_map.sv
module otpr_map #(
  parameter int AW          = 8,
  parameter int SMALL_WORDS = 4,
  parameter int SEG_WORDS   = 8,
  parameter int SEG_CNT     = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    lock_n,
  output logic          fault
);
  localparam int DATA_WORDS = SMALL_WORDS + SEG_CNT * SEG_WORDS;
  localparam logic [AW-1:0] LAST_A  = AW'(DATA_WORDS);
  localparam logic [AW-1:0] GROUPA_END = AW'(SMALL_WORDS + SEG_WORDS);

  logic in_range;
  logic is_lock_word;
  logic guarded;

  always_comb begin
    in_range     = (addr <= LAST_A);
    is_lock_word = (addr == '0);
    guarded      = (addr <= GROUPA_END) ? ~lock_n[0] : ~lock_n[1];
    fault        = ~in_range | (~is_lock_word & guarded);
  end
endmodule

// File: rtl/otpr_store.sv
module otpr_store #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int WORDS = 132
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_word,
  output logic [1:0]    lock_n
);
  localparam logic [AW-1:0] LAST_A = AW'(WORDS);

  logic [DW-1:0] view [WORDS+1];

  for (genvar g = 0; g <= WORDS; g++) begin : g_word
    if (g == 0) begin : g_lock
      logic [1:0] lk_q, lk_d;
      logic       lk_en;
      always_comb begin
        lk_en = we && (wr_addr == AW'(0));
        lk_d  = lk_q & wr_data[1:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     lk_q <= '1;
        else if (lk_en) lk_q <= lk_d;
      end
      assign view[g] = {{(DW-2){1'b1}}, lk_q};
    end else begin : g_data
      logic [DW-1:0] q, d;
      logic          en;
      always_comb begin
        en = we && (wr_addr == AW'(g));
        d  = q & wr_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '1;
        else if (en) q <= d;
      end
      assign view[g] = q;
    end
  end

  assign lock_n  = view[0][1:0];
  assign rd_word = (rd_addr <= LAST_A) ? view[rd_addr] : '1;
endmodule

// File: rtl/otp_prog_reg.sv
module otp_prog_reg #(
  parameter int AW          = 8,
  parameter int DW          = 16,
  parameter int SMALL_WORDS = 4,
  parameter int SEG_WORDS   = 8,
  parameter int SEG_CNT     = 16,
  parameter int PROG_LAT    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DATA_WORDS = SMALL_WORDS + SEG_CNT * SEG_WORDS;

  logic [1:0]    rst_sync_q;
  logic          rst_n_s;
  logic          armed, busy, commit, show_status, fault, store_we;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_data, stat_word, rd_word;
  logic [1:0]    lock_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  otpr_seq #(.AW(AW), .DW(DW), .PROG_LAT(PROG_LAT)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .fault(fault), .armed(armed), .busy(busy),
    .commit(commit), .show_status(show_status), .lat_addr(lat_addr),
    .lat_data(lat_data), .stat_word(stat_word)
  );

  otpr_map #(.AW(AW), .SMALL_WORDS(SMALL_WORDS), .SEG_WORDS(SEG_WORDS),
             .SEG_CNT(SEG_CNT)) u_map (
    .addr(lat_addr), .lock_n(lock_n), .fault(fault)
  );

  assign store_we = commit & ~fault;

  otpr_store #(.AW(AW), .DW(DW), .WORDS(DATA_WORDS)) u_store (
    .clk(clk), .rst_n(rst_n_s), .we(store_we), .wr_addr(lat_addr),
    .wr_data(lat_data), .rd_addr(rd_addr), .rd_word(rd_word), .lock_n(lock_n)
  );

  assign rd_data = show_status ? stat_word : rd_word;
endmodule

// File: rtl/otp_prog_reg_chk.sv
module otp_prog_reg_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n_s,
  input logic          bus_we,
  input logic          armed,
  input logic          busy,
  input logic          commit,
  input logic          fault,
  input logic [1:0]    lock_n,
  input logic [DW-1:0] lat_data,
  input logic [DW-1:0] rd_data
);
  a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n_s)
    (armed && bus_we) |=> busy);

  a_r4_busy_shows_status: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy |-> (rd_data[7] == 1'b0));

  a_r5_ready_after_commit: assert property (@(posedge clk) disable iff (!rst_n_s)
    commit |=> (!busy && rd_data[7]));

  a_r6_fault_flags_error: assert property (@(posedge clk) disable iff (!rst_n_s)
    (commit && fault) |=> rd_data[4]);

  a_r7_lock_a_sticky: assert property (@(posedge clk) disable iff (!rst_n_s)
    !lock_n[0] |=> !lock_n[0]);

  a_r7_lock_b_sticky: assert property (@(posedge clk) disable iff (!rst_n_s)
    !lock_n[1] |=> !lock_n[1]);

  a_r9_busy_holds_data: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && !commit && bus_we) |=> (busy && $stable(lat_data)));
endmodule

bind otp_prog_reg otp_prog_reg_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .bus_we(bus_we), .armed(armed), .busy(busy),
  .commit(commit), .fault(fault), .lock_n(lock_n), .lat_data(lat_data),
  .rd_data(rd_data)
);

// File: tb/test_otp_prog_reg.sv
module test_otp_prog_reg;
  localparam int AW  = 8;
  localparam int DW  = 16;
  localparam int LAT = 4;

  logic          clk;
  logic          rst_n;
  logic          bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;

  int n_vec;
  int n_bad;

  otp_prog_reg #(.AW(AW), .DW(DW), .PROG_LAT(LAT)) i_otp_prog_reg (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [DW-1:0] got,
                       input logic [DW-1:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic launch(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr(a, 16'h00C0);
    wr(a, d);
  endtask

  task automatic finish_op();
    repeat (LAT) @(negedge clk);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
    launch(a, d);
    finish_op();
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    rd(8'd0, v);   check("R1 lock word", v, 16'hFFFF);
    rd(8'd1, v);   check("R1 word 1", v, 16'hFFFF);
    rd(8'd132, v); check("R1 word 132", v, 16'hFFFF);
    wr(8'd0, 16'h0070);
    rd(8'd0, v);   check("R1 status", v, 16'h0080);
    wr(8'd0, 16'h00FF);
  endtask

  task automatic t_program();
    logic [DW-1:0] v;
    launch(8'd5, 16'hA5F0);
    rd(8'd5, v); check("R4 busy status", v, 16'h0000);
    finish_op();
    rd(8'd5, v); check("R5 idle status", v, 16'h0080);
    wr(8'd0, 16'h00FF);
    rd(8'd5, v); check("R3 word 5 written", v, 16'hA5F0);
    prog(8'd5, 16'h0FFF);
    rd(8'd5, v); check("R4 status after op", v, 16'h0080);
    wr(8'd0, 16'h00FF);
    rd(8'd5, v); check("R2 AND result", v, 16'h05F0);
  endtask

  task automatic t_latency();
    logic [DW-1:0] v;
    launch(8'd6, 16'h0000);
    rd(8'd6, v); check("R5 cycle 0 busy", v[7:0], 16'h0000);
    for (int k = 1; k < LAT; k++) begin
      @(negedge clk);
      rd(8'd6, v); check("R5 still busy", v, 16'h0000);
    end
    @(negedge clk);
    rd(8'd6, v); check("R5 ready at latency", v, 16'h0080);
  endtask

  task automatic t_ignore();
    logic [DW-1:0] v;
    launch(8'd7, 16'h1234);
    wr(8'd9, 16'h00FF);
    wr(8'd9, 16'h00C0);
    repeat (LAT - 2) @(negedge clk);
    rd(8'd7, v); check("R9 read mode kept", v, 16'h0080);
    wr(8'd9, 16'h5678);
    wr(8'd0, 16'h00FF);
    rd(8'd9, v); check("R9 arm ignored", v, 16'hFFFF);
    rd(8'd7, v); check("R9 data kept", v, 16'h1234);
  endtask

  task automatic t_range();
    logic [DW-1:0] v;
    prog(8'd132, 16'h0F0F);
    rd(8'd0, v); check("R6 last word ok", v, 16'h0080);
    prog(8'd133, 16'h0000);
    rd(8'd0, v); check("R6 out of range error", v, 16'h0090);
    wr(8'd0, 16'h0050);
    rd(8'd0, v); check("R10 error cleared", v, 16'h0080);
    wr(8'd0, 16'h00FF);
    rd(8'd133, v); check("R6 out of range read", v, 16'hFFFF);
    rd(8'd132, v); check("R6 word 132", v, 16'h0F0F);
  endtask

  task automatic t_locks();
    logic [DW-1:0] v;
    prog(8'd0, 16'hFFFE);
    wr(8'd0, 16'h00FF);
    rd(8'd0, v); check("R7 lock A set", v, 16'hFFFE);
    prog(8'd1, 16'h0000);
    rd(8'd0, v); check("R8 word 1 guarded", v, 16'h0090);
    wr(8'd0, 16'h0050);
    prog(8'd12, 16'h0000);
    rd(8'd0, v); check("R8 word 12 guarded", v, 16'h0090);
    wr(8'd0, 16'h0050);
    prog(8'd13, 16'h00FF);
    rd(8'd0, v); check("R8 word 13 open", v, 16'h0080);
    wr(8'd0, 16'h00FF);
    rd(8'd1, v);  check("R8 word 1 kept", v, 16'hFFFF);
    rd(8'd12, v); check("R8 word 12 kept", v, 16'hFFFF);
    rd(8'd13, v); check("R8 word 13 written", v, 16'h00FF);
    prog(8'd0, 16'hFFFF);
    wr(8'd0, 16'h00FF);
    rd(8'd0, v); check("R7 lock not undone", v, 16'hFFFE);
    prog(8'd0, 16'hFFFD);
    prog(8'd13, 16'h0000);
    rd(8'd0, v); check("R8 lock B error", v, 16'h0090);
    wr(8'd0, 16'h00FF);
    rd(8'd0, v);  check("R7 both locks", v, 16'hFFFC);
    rd(8'd13, v); check("R8 word 13 kept", v, 16'h00FF);
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0; n_bad = 0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_program();
    t_latency();
    t_ignore();
    t_range();
    t_locks();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule